// File: doc/BRIEF.md
# Radix-2^S Partial Product Generator with Negative-Digit Recoding

This block produces the partial products of an unsigned multiplication and leaves the summation to a separate stage. The multiplier operand is cut into groups of S bits, starting from the least significant end. Each group picks one small multiple of the multiplicand and places it at that group's weight. Some group values would need a multiple that is costly to form. For those values the group picks a negative multiple instead and passes a carry of one into the group above it. A final extra row takes the carry that leaves the top group.

Negative rows are sent out as the bitwise complement of the selected multiple, shifted into place. Each row has an increment bit beside it, and that bit completes the two's complement negation at the row's own weight. This means no row needs its own adder. A downstream tree adds the rows and the increment bits and obtains the product. A start pulse captures the operands. One cycle later the results appear on registered outputs together with a one-cycle valid strobe, and they stay unchanged until the next start.

Top module: `booth_ppg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `valid_o` low, every row of `pp_o` zero and every bit of `inc_o` zero.
- R2: `valid_o` is high in exactly the cycle after a cycle in which `start_i` was high at the rising edge, and it is low at all other times.
- R3: Rows and increment bits change only at an edge where `start_i` is high. At all other edges they hold their values.
- R4: The output has P = ceil(M/S)+1 rows, each W = NW+M+2 bits wide. Row k occupies `pp_o[k*W +: W]`, and its increment bit `inc_o[k]` has weight 2^(S*k). The sum of all rows plus all weighted increment bits, taken modulo 2^W, equals the multiplicand times the multiplier.
- R5: Group k is multiplier bits [S*k+S-1 : S*k], with zeros above bit M-1. Its digit is d = group value + carry-in, and group 0 has carry-in 0. If d ≤ 2^(S-1), row k equals d·N·2^(S*k), `inc_o[k]` is 0 and the carry-out is 0.
- R6: If 2^(S-1) < d < 2^S, row k is the W-bit complement of (2^S−d)·N, shifted left by S*k with zero fill. In that case `inc_o[k]` is 1 and the carry-out is 1. If d = 2^S, row k is zero, `inc_o[k]` is 0 and the carry-out is 1.
- R7: The last row, P−1, equals (carry out of the top group)·N·2^(S*(P−1)), and its increment bit is always 0.
- R8: The lowest S*k bits of row k are always zero.
- R9: With S=3, digit magnitudes range from 0 to 4. The magnitude 3 uses a precomputed 3N, and all other magnitudes are shifts of N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture the operands and produce the rows |
| mcand_i | input | NW | Unsigned multiplicand N |
| mplier_i | input | M | Unsigned multiplier |
| pp_o | output | P*W | Rows; row k at bits [k*W +: W] |
| inc_o | output | P | Per-row negation increment, weight 2^(S*k) |
| valid_o | output | 1 | One-cycle strobe when new rows are present |

## Verification
Every result of this block is due exactly one rising edge after the start pulse that carries its operands. The same edge makes the valid strobe rise, and the values then persist through any number of idle cycles. The bench's behavioural model updates its expected rows, increment bits and strobe at the same rising edge as the design. The bench compares them at the following falling edge, every cycle, so each check sees the one-cycle latency and the hold behaviour directly. Both S=2 and S=3 instances run back-to-back starts, idle gaps, all-ones and alternating multipliers, and a large set of random operands.

// File: rtl/booth_ppg_pkg.sv
// Package: shared types and helpers for the partial product generator.
// Assumes group width S is at most 3, so a digit magnitude fits in 3 bits.
package booth_ppg_pkg;

    // One recoded digit: sign flag and magnitude (0..4).
    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } bpg_digit_t;

    // Number of S-bit groups needed to cover an M-bit multiplier.
    function automatic int bpg_groups(input int m, input int s);
        return (m + s - 1) / s;
    endfunction

endpackage

// File: rtl/bpg_recode.sv
// Module: bpg_recode
// Splits the multiplier into S-bit groups, adds the carry from the group
// below, and maps each digit to a signed-magnitude selection. Digits above
// 2^(S-1) become negative with a carry into the next group. An extra top
// digit holds the final carry. Purely combinational.
// Assumes S in {2,3}.
module bpg_recode
    import booth_ppg_pkg::*;
#(
    parameter int M = 8,
    parameter int S = 2,
    parameter int G = bpg_groups(M, S)
) (
    input  logic [M-1:0]           mplier_i,
    output bpg_digit_t [G:0]       dig_o
);

    localparam int PW = G * S;
    localparam logic [S:0] THR  = (S+1)'(1) << (S - 1);
    localparam logic [S:0] FULL = (S+1)'(1) << S;

    logic [PW-1:0] padded;
    assign padded = PW'(mplier_i);

    // Purpose: ripple the carry through the groups and select each digit.
    always_comb begin
        logic [S:0] d;
        logic       c;
        dig_o = '0;
        c     = 1'b0;
        for (int g = 0; g < G; g++) begin
            d = {1'b0, padded[g*S +: S]} + {{S{1'b0}}, c};
            if (d > THR) begin
                c = 1'b1;
                if (d == FULL) begin
                    dig_o[g].neg = 1'b0;
                    dig_o[g].mag = 3'd0;
                end else begin
                    dig_o[g].neg = 1'b1;
                    dig_o[g].mag = 3'(FULL - d);
                end
            end else begin
                c = 1'b0;
                dig_o[g].neg = 1'b0;
                dig_o[g].mag = 3'(d);
            end
        end
        dig_o[G].neg = 1'b0;
        dig_o[G].mag = {2'b00, c};
    end

endmodule

// File: rtl/bpg_row.sv
// Module: bpg_row
// Forms one row: picks a multiple of N from the digit magnitude, takes the
// bitwise complement for a negative digit, and shifts left by SH with zero
// fill. The +1 that completes the negation is carried outside as a separate
// bit. Combinational. Assumes magnitude 3 occurs only when S=3.
module bpg_row
    import booth_ppg_pkg::*;
#(
    parameter int NW = 8,
    parameter int MW = NW + 2,
    parameter int W  = 18,
    parameter int SH = 0
) (
    input  logic [NW-1:0] mcand_i,
    input  logic [MW-1:0] triple_i,
    input  bpg_digit_t    dig_i,
    output logic [W-1:0]  pp_o
);

    logic [MW-1:0] mult;
    logic [W-1:0]  body;

    // Purpose: select the magnitude multiple without any adder.
    always_comb begin
        unique case (dig_i.mag)
            3'd1:    mult = MW'(mcand_i);
            3'd2:    mult = MW'(mcand_i) << 1;
            3'd3:    mult = triple_i;
            3'd4:    mult = MW'(mcand_i) << 2;
            default: mult = '0;
        endcase
    end

    // Purpose: fold in the negation and align the row at its weight.
    always_comb begin
        body = {{(W-MW){1'b0}}, mult};
        if (dig_i.neg) body = ~body;
        pp_o = body << SH;
    end

endmodule

// File: rtl/booth_ppg.sv
// Module: booth_ppg (top)
// Generalized negative-digit partial product generator. On start it
// captures the operands' rows and increment bits into registers and raises
// valid for one cycle. Rows hold until the next start.
// Assumes S in {2,3}; the summation is done elsewhere.
module booth_ppg
    import booth_ppg_pkg::*;
#(
    parameter int M  = 8,
    parameter int NW = 8,
    parameter int S  = 2,
    localparam int G   = bpg_groups(M, S),
    localparam int P   = G + 1,
    localparam int W   = NW + M + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [NW-1:0]  mcand_i,
    input  logic [M-1:0]   mplier_i,
    output logic [P*W-1:0] pp_o,
    output logic [P-1:0]   inc_o,
    output logic           valid_o
);

    localparam int MW = NW + 2;

    bpg_digit_t [G:0]      dig;
    logic [MW-1:0]         triple;
    logic [P-1:0][W-1:0]   pp_comb;
    logic [P-1:0]          inc_comb;
    logic [P-1:0][W-1:0]   pp_q;
    logic [P-1:0]          inc_q;

    // Hard multiple: only a 3-bit group needs 3N; 2-bit groups never do.
    generate
        if (S == 3) begin : g_triple
            assign triple = MW'(mcand_i) + (MW'(mcand_i) << 1);
        end else begin : g_no_triple
            assign triple = '0;
        end
    endgenerate

    bpg_recode #(.M(M), .S(S), .G(G)) u_recode (
        .mplier_i (mplier_i),
        .dig_o    (dig)
    );

    generate
        for (genvar k = 0; k < P; k++) begin : g_row
            bpg_row #(.NW(NW), .MW(MW), .W(W), .SH(S*k)) u_row (
                .mcand_i  (mcand_i),
                .triple_i (triple),
                .dig_i    (dig[k]),
                .pp_o     (pp_comb[k])
            );
            assign inc_comb[k] = dig[k].neg;
        end
    endgenerate

    // Purpose: register rows on start and produce the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_q    <= '0;
            inc_q   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                pp_q  <= pp_comb;
                inc_q <= inc_comb;
            end
        end
    end

    assign pp_o  = pp_q;
    assign inc_o = inc_q;

    // Folds rows and weighted increments back into a product, for checking.
    function automatic logic [W-1:0] fold_rows(input logic [P-1:0][W-1:0] r,
                                               input logic [P-1:0] c);
        logic [W-1:0] acc;
        acc = '0;
        for (int k = 0; k < P; k++) acc = acc + r[k] + (W'(c[k]) << (S*k));
        return acc;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && pp_q == '0 && inc_q == '0)); // R1

    AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o); // R2

    AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(start_i)); // R2

    AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(pp_q) && $stable(inc_q))); // R3

    AST_SUM_IS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> fold_rows(pp_q, inc_q) ==
                    W'(W'($past(mcand_i)) * W'($past(mplier_i)))); // R4

    AST_TOP_ROW_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !inc_q[P-1]); // R7

    generate
        for (genvar k = 1; k < P; k++) begin : g_chk
            localparam logic [W-1:0] LOWMASK = (W'(1) << (S*k)) - W'(1);
            AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o |-> (pp_q[k] & LOWMASK) == '0); // R8
        end
        for (genvar k = 0; k < P; k++) begin : g_neg
            AST_NEG_ROW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
                inc_q[k] |-> pp_q[k] != '0); // R6
        end
    endgenerate

endmodule

// File: tb/test_booth_ppg.sv
// Bench: cycle-by-cycle behavioural model for an S=2 and an S=3 instance,
// compared at every falling edge.
module test_booth_ppg;

    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] n_in = '0;
    logic [7:0] m_in = '0;

    logic [5*W-1:0] pp_a;
    logic [4:0]     inc_a;
    logic           v_a;
    logic [4*W-1:0] pp_b;
    logic [3:0]     inc_b;
    logic           v_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    booth_ppg #(.M(8), .NW(8), .S(2)) i_booth_ppg (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(n_in),
        .mplier_i(m_in), .pp_o(pp_a), .inc_o(inc_a), .valid_o(v_a));

    booth_ppg #(.M(8), .NW(8), .S(3)) i_booth_ppg_s3 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(n_in),
        .mplier_i(m_in), .pp_o(pp_b), .inc_o(inc_b), .valid_o(v_b));

    // Model state
    logic [4:0][W-1:0] ma, mb;
    logic [4:0]        ia, ib;
    logic              va, vb;
    logic [7:0]        last_n, last_m;

    // Expected rows from the digit rule of the requirements.
    task automatic build(input int s, input int np, input logic [7:0] n,
                         input logic [7:0] mp, output logic [4:0][W-1:0] rows,
                         output logic [4:0] incs);
        int c, d, mag;
        logic [63:0] v;
        logic [63:0] mask;
        bit ng;
        mask = (64'd1 << W) - 1;
        rows = '0; incs = '0; c = 0;
        for (int g = 0; g < np; g++) begin
            if (g == np - 1) begin
                mag = c; ng = 0;
            end else begin
                d = ((int'(mp) >> (s*g)) & ((1 << s) - 1)) + c;
                if (d <= (1 << (s-1))) begin
                    mag = d; ng = 0; c = 0;
                end else if (d == (1 << s)) begin
                    mag = 0; ng = 0; c = 1;
                end else begin
                    mag = (1 << s) - d; ng = 1; c = 1;
                end
            end
            v = 64'(mag) * 64'(n);
            if (ng) v = ~v;
            rows[g] = W'((v << (s*g)) & mask);
            incs[g] = ng;
        end
    endtask

    // Purpose: reference model advances on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            ma = '0; mb = '0; ia = '0; ib = '0; va = 0; vb = 0;
        end else begin
            va = start; vb = start;
            if (start) begin
                build(2, 5, n_in, m_in, ma, ia);
                build(3, 4, n_in, m_in, mb, ib);
                last_n = n_in; last_m = m_in;
            end
        end
    end

    task automatic check(input string rq, input string tg,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, tg, act, exp);
        end
    endtask

    task automatic check_inst(input string tg, input int s, input int np,
                              input logic [5*W-1:0] pp, input logic [4:0] inc,
                              input logic v, input logic [4:0][W-1:0] mr,
                              input logic [4:0] mi, input logic mv);
        logic [63:0] acc;
        string rq;
        check("R2", {tg, " valid"}, 64'(v), 64'(mv));
        acc = '0;
        for (int k = 0; k < np; k++) begin
            if (!mv)              rq = "R3";
            else if (k == np - 1) rq = "R7";
            else if (s == 3)      rq = "R9";
            else if (mi[k])       rq = "R6";
            else                  rq = "R5";
            check(rq, $sformatf("%s row%0d", tg, k), 64'(pp[k*W +: W]), 64'(mr[k]));
            check(rq, $sformatf("%s inc%0d", tg, k), 64'(inc[k]), 64'(mi[k]));
            if (mv && k > 0)
                check("R8", $sformatf("%s low%0d", tg, k),
                      64'(pp[k*W +: W]) & ((64'd1 << (s*k)) - 1), 64'd0);
            acc = acc + 64'(pp[k*W +: W]) + (64'(inc[k]) << (s*k));
        end
        if (mv)
            check("R4", {tg, " sum"}, acc & ((64'd1 << W) - 1),
                  64'(last_n) * 64'(last_m));
    endtask

    // Purpose: compare every cycle once out of reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_inst("s2", 2, 5, pp_a, inc_a, v_a, ma, ia, va);
            check_inst("s3", 3, 4, {{W{1'b0}}, pp_b}, {1'b0, inc_b}, v_b, mb, ib, vb);
        end
    end

    task automatic apply(input logic [7:0] n, input logic [7:0] mp, input int gap);
        @(negedge clk);
        n_in = n; m_in = mp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_in = ~n; m_in = ~mp;   // operand changes while idle must not matter (R3)
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1", "valid", 64'(v_a), 64'd0);
        check("R1", "rows", 64'(pp_a != '0) | 64'(pp_b != '0), 64'd0);
        check("R1", "incs", 64'(inc_a) | 64'(inc_b), 64'd0);
        apply(8'd0,   8'd0,   1);
        apply(8'd255, 8'd255, 2);
        apply(8'd1,   8'd255, 0);
        apply(8'd255, 8'hAA,  0);
        apply(8'h5A,  8'h55,  3);
        apply(8'd7,   8'h77,  1);
        apply(8'd200, 8'hDB,  0);
        apply(8'd255, 8'h80,  2);
        apply(8'd131, 8'h6E,  1);
        for (int i = 0; i < 400; i++)
            apply(8'($urandom), 8'($urandom), int'($urandom % 3));
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule